// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to an operational state. Once reset is released it keeps clock enable and the data mask high and presents a no-operation on the command pins for a stable-power interval. The length of that interval is computed from a clock-frequency parameter and a wait time in microseconds. It then precharges every bank. After that it issues a configurable number of auto-refresh commands and one mode-register load, in an order chosen by a configuration input. Finally it raises a ready flag that hands the memory over to the normal controller.

The mode word comes from four configuration inputs: burst length, burst type, CAS latency and write-burst mode. These inputs, together with the order select, are sampled once, at the moment the precharge is issued. A combination the memory reserves raises an error flag at that moment, and the sequencer then stays idle without issuing any command. Each command is followed by its own parameterized recovery gap before the next one may go out.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, and for WAIT_CYC = CLK_MHZ*WAIT_US cycles after its release, the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), dqm_o is 1, ready_o is 0 and cfg_err_o is 0.
- R2: With a valid configuration, the first command is precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, addr bit 10 = 1, all other address and bank bits 0). It appears in output cycle WAIT_CYC+1 after reset release.
- R3: Exactly N_REF auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1, address and bank 0) are issued per sequence.
- R4: The mode-register load (all four command pins 0) drives burst length on addr[2:0], burst type on addr[3] (0 sequential, 1 interleave), CAS latency on addr[6:4], 00 on addr[8:7], write-burst mode on addr[9] (1 = single-location writes), and 0 on addr[10], on the upper address bits and on the bank bits.
- R5: If mrs_first_i is 0 when sampled, the refreshes come before the mode-register load. If it is 1, the mode-register load comes first.
- R6: A command follows a precharge after T_RP cycles, a refresh after T_RC cycles and a mode-register load after T_MRD cycles. Every cycle in between carries NOP.
- R7: ready_o rises one gap of the last command after that command. It then stays 1, with NOP on the pins and dqm_o at 0, until reset.
- R8: A configuration is reserved if CAS latency is not 2 or 3, if the burst-length code is 4, 5 or 6, or if code 7 (full page) is paired with interleave. A reserved configuration sets cfg_err_o in cycle WAIT_CYC+1 and keeps it set until reset. No command is ever issued and ready_o stays 0.
- R9: The configuration inputs are sampled only when the precharge is issued. Later changes have no effect on the sequence.
- R10: Asserting rst_ni low part-way through restarts the whole sequence from the wait interval.
- R11: cke_o is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| burst_len_i | input | 3 | Burst-length code (0=1, 1=2, 2=4, 3=8, 7=full page) |
| burst_type_i | input | 1 | 0 sequential, 1 interleave |
| cas_lat_i | input | 3 | CAS latency code (2 or 3) |
| wr_single_i | input | 1 | 1 = single-location writes, burst reads |
| mrs_first_i | input | 1 | 1 = mode-register load before the refreshes |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dqm_o | output | 1 | Data mask |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | BA_W | Bank address |
| ready_o | output | 1 | Initialization complete |
| cfg_err_o | output | 1 | Reserved configuration detected |

## Verification
Some properties are checked by the assertions on every cycle. Clock enable stays high. The mask stays high until ready. The pins stay quiet once ready or in error, and ready never falls. Every precharge carries bit 10 set. Every mode-register load carries zero reserved bits. The captured configuration does not move after the start. The refresh count never passes its limit. Other properties can only be shown by the bench's scenarios, which compare every cycle against a queue-based model. These are the exact cycle of each command, the gap lengths, the two orderings, the mode-word field contents, error detection for each class of reserved code, the sampling of the configuration at start, and the restart after a mid-sequence reset.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE_GAP,
    ST_REF_GAP,
    ST_MRS_GAP,
    ST_DONE,
    ST_ERR
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic pins_t cmd_pins(cmd_e c);
    pins_t p;
    unique case (c)
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = PINS_NOP;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              wr_single_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] word_o
);

  logic cl_ok, bl_ok;

  always_comb begin
    cl_ok = (cas_lat_i == 3'd2) || (cas_lat_i == 3'd3);
    // full page only with sequential type
    bl_ok = (burst_len_i <= 3'd3) || ((burst_len_i == 3'd7) && !burst_type_i);
    valid_o = cl_ok && bl_ok;

    word_o      = '0;
    word_o[2:0] = burst_len_i;
    word_o[3]   = burst_type_i;
    word_o[6:4] = cas_lat_i;
    word_o[9]   = wr_single_i;
  end

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int TW      = 15,
  parameter int RST_VAL = 20000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= TW'(RST_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // expired timer holds until reloaded
  assert_zero_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cke_o,
  output pins_t             pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o  <= 1'b1;
      pins_o <= PINS_NOP;
      addr_o <= '0;
      ba_o   <= '0;
    end else begin
      cke_o  <= 1'b1;
      pins_o <= cmd_pins(cmd_i);
      addr_o <= addr_i;
      ba_o   <= '0;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int WAIT_US = 200,
  parameter int N_REF   = 2,
  parameter int T_RP    = 3,
  parameter int T_RC    = 9,
  parameter int T_MRD   = 2,
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              wr_single_i,
  input  logic              mrs_first_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              dqm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ready_o,
  output logic              cfg_err_o
);

  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int GAP_MAX  = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                          : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int CNT_MAX  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
  localparam int TW       = $clog2(CNT_MAX + 1);
  localparam int RW       = $clog2(N_REF + 1);
  localparam int AP_BIT   = 10;

  state_e            state_q, state_d;
  logic [RW-1:0]     ref_q, ref_d;
  logic [ADDR_W-1:0] word_q, word_live;
  logic              mrs_first_q;
  logic              cfg_ok, start, tmr_zero, load;
  logic [TW-1:0]     load_val;
  logic              go_ref, go_mrs;
  cmd_e              cmd;
  logic [ADDR_W-1:0] cmd_addr;
  pins_t             pins;

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .burst_len_i (burst_len_i),
    .burst_type_i(burst_type_i),
    .cas_lat_i   (cas_lat_i),
    .wr_single_i (wr_single_i),
    .valid_o     (cfg_ok),
    .word_o      (word_live)
  );

  sdram_gap_timer #(.TW(TW), .RST_VAL(WAIT_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .val_i (load_val),
    .zero_o(tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    cmd      = CMD_NOP;
    cmd_addr = '0;
    load     = 1'b0;
    load_val = '0;
    start    = 1'b0;
    go_ref   = 1'b0;
    go_mrs   = 1'b0;
    if (tmr_zero) begin
      unique case (state_q)
        ST_WAIT: begin
          if (!cfg_ok) begin
            state_d = ST_ERR;
          end else begin
            start            = 1'b1;
            cmd              = CMD_PRE;
            cmd_addr[AP_BIT] = 1'b1;
            load             = 1'b1;
            load_val         = TW'(T_RP - 1);
            ref_d            = '0;
            state_d          = ST_PRE_GAP;
          end
        end
        ST_PRE_GAP: begin
          go_mrs = mrs_first_q;
          go_ref = !mrs_first_q;
        end
        ST_REF_GAP: begin
          if (ref_q < RW'(N_REF)) go_ref = 1'b1;
          else if (mrs_first_q)   state_d = ST_DONE;
          else                    go_mrs = 1'b1;
        end
        ST_MRS_GAP: begin
          if (mrs_first_q) go_ref = 1'b1;
          else             state_d = ST_DONE;
        end
        default: ;
      endcase
    end
    if (go_ref) begin
      cmd      = CMD_REF;
      load     = 1'b1;
      load_val = TW'(T_RC - 1);
      ref_d    = ref_q + 1'b1;
      state_d  = ST_REF_GAP;
    end
    if (go_mrs) begin
      cmd      = CMD_MRS;
      cmd_addr = word_q;
      load     = 1'b1;
      load_val = TW'(T_MRD - 1);
      state_d  = ST_MRS_GAP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_WAIT;
      ref_q       <= '0;
      word_q      <= '0;
      mrs_first_q <= 1'b0;
      ready_o     <= 1'b0;
      cfg_err_o   <= 1'b0;
      dqm_o       <= 1'b1;
    end else begin
      state_q   <= state_d;
      ref_q     <= ref_d;
      ready_o   <= (state_d == ST_DONE);
      cfg_err_o <= (state_d == ST_ERR);
      dqm_o     <= (state_d != ST_DONE);
      if (start) begin
        word_q      <= word_live;
        mrs_first_q <= mrs_first_i;
      end
    end
  end

  sdram_cmd_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_cmd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd),
    .addr_i(cmd_addr),
    .cke_o (cke_o),
    .pins_o(pins),
    .addr_o(addr_o),
    .ba_o  (ba_o)
  );

  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;

  logic [3:0] pin_vec;
  assign pin_vec = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  assert_cke_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o);

  assert_dqm_until_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> dqm_o);

  assert_pre_all_banks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_vec == 4'b0010) |-> addr_o[AP_BIT]);

  assert_ref_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q <= RW'(N_REF));

  assert_mrs_reserved_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_vec == 4'b0000) |-> (ba_o == '0 && !addr_o[AP_BIT] && addr_o[8:7] == 2'b00));

  assert_quiet_when_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (pin_vec == 4'b0111 && !dqm_o));

  assert_ready_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  assert_err_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (pin_vec == 4'b0111 && !ready_o));

  assert_cfg_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_WAIT && $past(state_q) != ST_WAIT) |-> ($stable(word_q) && $stable(mrs_first_q)));

endmodule

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

  localparam int CLK_MHZ = 100;
  localparam int WAIT_US = 3;
  localparam int N_REF   = 3;
  localparam int T_RP    = 3;
  localparam int T_RC    = 7;
  localparam int T_MRD   = 2;
  localparam int WAIT    = CLK_MHZ * WAIT_US;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] burst_len = 3'd0, cas_lat = 3'd2;
  logic burst_type = 1'b0, wr_single = 1'b0, mrs_first = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, dqm, ready, cfg_err;
  logic [11:0] addr;
  logic [1:0] ba;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .N_REF(N_REF),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .ADDR_W(12), .BA_W(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .burst_len_i(burst_len), .burst_type_i(burst_type), .cas_lat_i(cas_lat),
    .wr_single_i(wr_single), .mrs_first_i(mrs_first),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .dqm_o(dqm), .addr_o(addr), .ba_o(ba), .ready_o(ready), .cfg_err_o(cfg_err)
  );

  typedef struct packed {
    logic [3:0]  pins;
    logic [11:0] addr;
    logic [1:0]  ba;
    logic        rdy;
    logic        err;
    logic        dqm;
    logic [7:0]  tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t steady;

  function automatic exp_t mk(logic [3:0] p, logic [11:0] a, logic r, logic e, logic d, int t);
    exp_t x;
    x.pins = p; x.addr = a; x.ba = 2'b00; x.rdy = r; x.err = e; x.dqm = d; x.tag = 8'(t);
    return x;
  endfunction

  function automatic void push(int n, exp_t x);
    for (int k = 0; k < n; k++) exp_q.push_back(x);
  endfunction

  // reference model: expected per-cycle output stream from the requirements
  function automatic void build(logic [2:0] bl, logic bt, logic [2:0] cl, logic wr, logic mf, int ovr);
    logic ok;
    logic [11:0] word;
    exp_t nop_g;
    exp_q.delete();
    ok = (cl == 3'd2 || cl == 3'd3) && (bl <= 3'd3 || (bl == 3'd7 && !bt));
    word = {2'b00, wr, 2'b00, cl, bt, bl};
    push(WAIT, mk(4'b0111, 12'h000, 1'b0, 1'b0, 1'b1, (ovr != 0) ? ovr : 1)); // R1
    nop_g = mk(4'b0111, 12'h000, 1'b0, 1'b0, 1'b1, (ovr != 0) ? ovr : 6);     // R6
    if (!ok) begin
      steady = mk(4'b0111, 12'h000, 1'b0, 1'b1, 1'b1, (ovr != 0) ? ovr : 8);  // R8
      return;
    end
    push(1, mk(4'b0010, 12'h400, 1'b0, 1'b0, 1'b1, (ovr != 0) ? ovr : 2));    // R2
    push(T_RP - 1, nop_g);
    if (mf) begin
      push(1, mk(4'b0000, word, 1'b0, 1'b0, 1'b1, (ovr != 0) ? ovr : 5));     // R5
      push(T_MRD - 1, nop_g);
    end
    for (int r = 0; r < N_REF; r++) begin
      push(1, mk(4'b0001, 12'h000, 1'b0, 1'b0, 1'b1, (ovr != 0) ? ovr : 3));  // R3
      push(T_RC - 1, nop_g);
    end
    if (!mf) begin
      push(1, mk(4'b0000, word, 1'b0, 1'b0, 1'b1, (ovr != 0) ? ovr : 4));     // R4
      push(T_MRD - 1, nop_g);
    end
    steady = mk(4'b0111, 12'h000, 1'b1, 1'b0, 1'b0, (ovr != 0) ? ovr : 7);    // R7
  endfunction

  task automatic check(exp_t e, int cyc);
    tests++;
    if ({cs_n, ras_n, cas_n, we_n} !== e.pins || addr !== e.addr || ba !== e.ba ||
        ready !== e.rdy || cfg_err !== e.err || dqm !== e.dqm) begin
      fails++;
      $display("FAIL R%0d cycle %0d: got pins=%b addr=%h ba=%h rdy=%b err=%b dqm=%b, expected pins=%b addr=%h ba=%h rdy=%b err=%b dqm=%b",
               e.tag, cyc, {cs_n, ras_n, cas_n, we_n}, addr, ba, ready, cfg_err, dqm,
               e.pins, e.addr, e.ba, e.rdy, e.err, e.dqm);
    end
    if (cke !== 1'b1) begin
      fails++;
      $display("FAIL R11 cycle %0d: got cke=%b expected 1", cyc, cke);
    end
  endtask

  task automatic run(logic [2:0] bl, logic bt, logic [2:0] cl, logic wr, logic mf,
                     int ovr, int abort_at);
    @(negedge clk);
    rst_ni = 1'b0;
    burst_len = bl; burst_type = bt; cas_lat = cl; wr_single = wr; mrs_first = mf;
    repeat (3) @(negedge clk);
    // R1: state held during reset
    check(mk(4'b0111, 12'h000, 1'b0, 1'b0, 1'b1, 1), -1);
    build(bl, bt, cl, wr, mf, ovr);
    rst_ni = 1'b1;
    for (int i = 0; i < exp_q.size(); i++) begin
      @(negedge clk);
      if (abort_at > 0 && i == abort_at) return;
      check(exp_q[i], i + 1);
      // R9: disturb inputs right after the precharge was seen
      if (ovr == 9 && i == WAIT) begin
        burst_len = 3'd5; cas_lat = 3'd7; mrs_first = ~mf; wr_single = ~wr;
      end
    end
    for (int s = 0; s < 10; s++) begin
      @(negedge clk);
      check(steady, exp_q.size() + s + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: got sequence still running, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    run(3'd3, 1'b0, 3'd3, 1'b0, 1'b0, 0, 0);  // R4 burst 8 seq CL3, refreshes first
    run(3'd7, 1'b0, 3'd2, 1'b1, 1'b1, 0, 0);  // R5 full page, MRS first, single writes
    run(3'd2, 1'b1, 3'd2, 1'b0, 1'b0, 0, 0);  // R4 burst 4 interleave
    run(3'd0, 1'b0, 3'd1, 1'b0, 1'b0, 0, 0);  // R8 bad CAS latency
    run(3'd7, 1'b1, 3'd3, 1'b0, 1'b0, 0, 0);  // R8 full page with interleave
    run(3'd5, 1'b0, 3'd2, 1'b0, 1'b1, 0, 0);  // R8 reserved burst code
    run(3'd1, 1'b0, 3'd3, 1'b1, 1'b0, 9, 0);  // R9 inputs change after start
    run(3'd1, 1'b1, 3'd2, 1'b0, 1'b1, 0, WAIT + 6);
    run(3'd0, 1'b0, 3'd3, 1'b0, 1'b0, 10, 0); // R10 restart after mid-sequence reset
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule